// File: doc/BRIEF.md
# Event Flag Bank with Two-Step Acknowledge

This block holds a small set of event flags for a peripheral. Each flag is set by a one-cycle pulse from the peripheral's own hardware. Each flag has its own enable bit. The block drives one request line per flag towards the chip's interrupt priority logic. A request is raised only when the flag is set, its enable is on, and the processor's global mask input is low. While either gate is closed, the flag itself keeps the request pending, and the request appears as soon as both gates open.

Software reaches the bank over a simple register bus with an address, a read strobe, a write strobe, write data, and combinational read data. There are two ways to acknowledge a flag:
- Write a zero to the flag's bit in the status register.
- Read the status register while the flag is set, then access that flag's own data register, either by a read or by a write.

Each data register is a plain storage word for software. Any acknowledge drops the flag. This also throws away any request that was waiting for its enable or for the mask.

Top module: `evt_flag_bank`

## Requirements
- R1: After reset, every flag, enable, arm bit and data register is zero, and every request is low.
- R2: A one-cycle pulse on event input bit i sets flag i at the next clock edge. Status reads at address 0 return flag i on bit i, with the upper bits zero.
- R3: Request bit i equals flag i AND enable i AND NOT global mask, with no clock delay. Enable bit i is bit i of the control register at address 1, which is written and read back there.
- R4: A flag whose enable is off or whose mask is high stays set. Its request appears as soon as enable is on and mask is low.
- R5: A write to the status register clears every flag whose data bit is 0. A data bit of 1 leaves its flag unchanged, so a set flag stays set and a clear flag stays clear.
- R6: A status read that sees flag i set arms flag i. The next bus access, if it is a read or a write of data register i at address 2+i, clears flag i.
- R7: A status read taken while flag i is clear does not arm flag i. This holds even when an event sets the flag in that same cycle, so a later access to data register i leaves the flag set.
- R8: Every bus access other than a status read disarms all flags, and that includes the data access that uses an arm. As a result, after one status read, only the first data access can clear anything.
- R9: An event pulse in the same cycle as any acknowledge of that flag wins, and the flag stays set.
- R10: An acknowledge discards a pending request: once a masked or disabled flag is cleared, opening the gates later raises no request.
- R11: Writing data register i stores the write data, and reading it returns that value. Reads of unused addresses, and read data while the read strobe is low, are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | N | Event set pulses, one per flag |
| gmask_i | input | 1 | Global interrupt mask, high blocks all requests |
| addr_i | input | AW | Register address: 0 status, 1 control, 2+i data register i |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Read data, valid in the strobe cycle |
| req_o | output | N | Request lines to the priority logic |

## Verification
The bench goes after these corner cases:
- **Partial status writes.** It sweeps every flag pattern against every status write value. A design that treated ones as sets, or cleared all bits, fails here.
- **Request gating.** It sweeps every flag, enable and mask combination. A registered or mis-gated request shows up as a mismatch.
- **Sequence clears.** Each is tried with both a read and a write of the data register. An intervening access and a second data access after one status read are also tried. A design that keeps the arm alive too long clears flags the software never saw.
- **Collisions and pending requests.** An event colliding with each kind of clear must leave the flag set. A request pending behind the mask must not return after its acknowledge. A design that kept a separate pending latch would raise a stale request.

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int N  = 4,
  parameter int W  = 8,
  parameter int AW = $clog2(N + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  evt_i,
  input  logic          gmask_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic [N-1:0]  req_o
);

  localparam logic [AW-1:0] A_STAT = '0;
  localparam logic [AW-1:0] A_CTRL = AW'(1);
  localparam int DBASE = 2;

  logic [N-1:0] flag_q, en_q, arm_q, dhit, clr;
  logic [W-1:0] dreg_q [N];

  wire acc     = rd_i | wr_i;
  wire stat_rd = rd_i && (addr_i == A_STAT);
  wire stat_wr = wr_i && (addr_i == A_STAT);
  wire ctrl_wr = wr_i && (addr_i == A_CTRL);

  for (genvar i = 0; i < N; i++) begin : g_data
    assign dhit[i] = acc && (addr_i == AW'(DBASE + i));
    always_ff @(posedge clk) begin
      if (!rst_n)                dreg_q[i] <= '0;
      else if (wr_i && dhit[i])  dreg_q[i] <= wdata_i;
    end
  end

  assign clr   = ({N{stat_wr}} & ~wdata_i[N-1:0]) | (dhit & arm_q);
  assign req_o = flag_q & en_q & {N{~gmask_i}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      arm_q  <= '0;
    end else begin
      flag_q <= evt_i | (flag_q & ~clr);
      if (ctrl_wr) en_q <= wdata_i[N-1:0];
      if (acc)     arm_q <= stat_rd ? flag_q : '0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i == A_STAT) rdata_o = W'(flag_q);
      if (addr_i == A_CTRL) rdata_o = W'(en_q);
      for (int i = 0; i < N; i++)
        if (dhit[i]) rdata_o = dreg_q[i];
    end
  end

  // R2
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

  // R5
  wr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && evt_i == '0) |=> ((flag_q & ~$past(flag_q)) == '0));

  // R6
  seq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((dhit & arm_q) != '0) && evt_i == '0) |=> ((flag_q & $past(dhit & arm_q)) == '0));

  // R7
  arm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> ((arm_q & ~$past(flag_q)) == '0));

  // R8
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !stat_rd) |=> (arm_q == '0));

endmodule

// File: tb/sim_evt_flag_bank.sv
module sim_evt_flag_bank;
  logic clk = 0, rst_n = 0, gmask = 0, rd = 0, wr = 0;
  logic [3:0] evt = '0;
  logic [2:0] addr = '0;
  logic [7:0] wd = '0, rdata;
  logic [3:0] req;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  evt_flag_bank #(.N(4), .W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .gmask_i(gmask), .addr_i(addr),
    .rd_i(rd), .wr_i(wr), .wdata_i(wd), .rdata_o(rdata), .req_o(req));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic r, input logic w, input logic [2:0] a,
                     input logic [7:0] d, input logic [3:0] e, output logic [7:0] q);
    @(negedge clk);
    rd = r; wr = w; addr = a; wd = d; evt = e;
    #1 q = rdata;
    @(posedge clk);
    #1 rd = 0; wr = 0; evt = 0; wd = '0;
  endtask

  task automatic pulse(input logic [3:0] e);
    logic [7:0] q;
    bus(0, 0, 0, 0, e, q);
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [7:0] q);
    bus(1, 0, a, 0, 0, q);
  endtask

  task automatic wrreg(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] q;
    bus(0, 1, a, d, 0, q);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk("R1 req", {4'h0, req}, 8'h00);
    rdreg(0, q); chk("R1 status", q, 8'h00);
    rdreg(1, q); chk("R1 ctrl", q, 8'h00);
    for (int i = 0; i < 4; i++) begin
      rdreg(3'(2 + i), q); chk("R1 data", q, 8'h00);
    end

    // R2 / R5 sweep: every flag pattern against every status write value
    for (int p = 0; p < 16; p++) begin
      for (int v = 0; v < 16; v++) begin
        wrreg(0, 8'h00);
        pulse(4'(p));
        rdreg(0, q); chk("R2 status set", q, 8'(p));
        wrreg(0, {4'hF, 4'(v)});
        rdreg(0, q); chk("R5 partial write", q, 8'(p & v));
      end
    end
    wrreg(0, 8'h00); wrreg(0, 8'hFF);
    rdreg(0, q); chk("R5 write one no set", q, 8'h00);

    // R3 sweep: flag x enable x mask
    for (int f = 0; f < 16; f++)
      for (int e = 0; e < 16; e++)
        for (int m = 0; m < 2; m++) begin
          wrreg(0, 8'h00);
          pulse(4'(f));
          wrreg(1, 8'(e));
          gmask = m[0];
          #1 chk("R3 req gate", {4'h0, req}, 8'((f & e) & (m ? 0 : 15)));
        end
    rdreg(1, q); chk("R3 ctrl readback", q, 8'h0F);
    gmask = 0;

    // R4 pending held, then released
    wrreg(0, 8'h00); wrreg(1, 8'h00);
    pulse(4'h4);
    chk("R4 held req", {4'h0, req}, 8'h00);
    gmask = 1; wrreg(1, 8'h04);
    chk("R4 masked req", {4'h0, req}, 8'h00);
    rdreg(0, q); chk("R4 flag kept", q, 8'h04);
    gmask = 0; #1;
    chk("R4 released req", {4'h0, req}, 8'h04);

    // R6 sequence clear, read and write data access
    for (int i = 0; i < 4; i++)
      for (int k = 0; k < 2; k++) begin
        wrreg(0, 8'h00); pulse(4'hF);
        rdreg(0, q);
        if (k == 0) rdreg(3'(2 + i), q); else wrreg(3'(2 + i), 8'h5A);
        rdreg(0, q); chk("R6 seq clear", q, 8'(4'hF & ~(4'b1 << i)));
      end

    // R7 not armed when clear at status read (event in same cycle)
    for (int i = 0; i < 4; i++) begin
      wrreg(0, 8'h00);
      bus(1, 0, 0, 0, 4'(1 << i), q);
      chk("R7 status old", q, 8'h00);
      rdreg(3'(2 + i), q);
      rdreg(0, q); chk("R7 no arm", q, 8'(1 << i));
    end

    // R8 intervening access disarms; only first data access clears
    wrreg(0, 8'h00); pulse(4'h2);
    rdreg(0, q); rdreg(1, q); rdreg(3, q);
    rdreg(0, q); chk("R8 intervening", q, 8'h02);
    wrreg(0, 8'h00); pulse(4'h3);
    rdreg(0, q); rdreg(2, q); rdreg(3, q);
    rdreg(0, q); chk("R8 second data", q, 8'h02);
    wrreg(0, 8'h00); pulse(4'h1);
    rdreg(0, q); wrreg(1, 8'h00); wrreg(2, 8'h00);
    rdreg(0, q); chk("R8 ctrl write", q, 8'h01);

    // R9 event beats write clear and sequence clear
    wrreg(0, 8'h00); pulse(4'h8);
    bus(0, 1, 0, 8'h00, 4'h8, q);
    rdreg(0, q); chk("R9 vs write", q, 8'h08);
    rdreg(0, q);
    bus(1, 0, 5, 0, 4'h8, q);
    rdreg(0, q); chk("R9 vs sequence", q, 8'h08);

    // R10 clear discards pending request
    wrreg(0, 8'h00); gmask = 1; wrreg(1, 8'h0F);
    pulse(4'h1);
    wrreg(0, 8'hFE);
    gmask = 0; #1;
    chk("R10 write lost", {4'h0, req}, 8'h00);
    wrreg(1, 8'h00); pulse(4'h2);
    rdreg(0, q); rdreg(3, q);
    wrreg(1, 8'h0F);
    chk("R10 sequence lost", {4'h0, req}, 8'h00);
    wrreg(1, 8'h00);

    // R11 data storage and unused reads
    for (int i = 0; i < 4; i++) wrreg(3'(2 + i), 8'(8'h31 * (i + 1)));
    for (int i = 0; i < 4; i++) begin
      rdreg(3'(2 + i), q); chk("R11 data readback", q, 8'(8'h31 * (i + 1)));
    end
    rdreg(6, q); chk("R11 unused 6", q, 8'h00);
    rdreg(7, q); chk("R11 unused 7", q, 8'h00);
    @(negedge clk); addr = 2; #1 chk("R11 idle rdata", rdata, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule